// File: doc/BRIEF.md
# Timed Register Bit-Flip Injection Scheduler

This block plans a single deliberate upset in one processor register of a lockstepped pair, timed inside one chosen code block of the running program. Software loads a configuration through a valid/ready write channel. The configuration names the target block, a cycle offset measured from the start of that block, the core to corrupt, the register index, the bit index and an arm flag. The block follows the program's progress through a pulse on every verification-point entry. A second input marks the verification point that opens execution, which restarts the block numbering at zero.

Once armed, the scheduler waits for the chosen block to begin and then counts clock cycles. When the count equals the offset, it raises an interrupt pulse on both cores in the same cycle, so that the lockstep timing stays symmetric. It also presents the target core, the register index and a 32-bit one-hot XOR mask. The interrupt handler on each core reads these, and only the selected core applies the mask. These values stay held until software acknowledges them. The injection fires once and then disarms. A write with the arm flag clear disables injection and leaves consistency checking to run alone.

The configuration channel never applies back-pressure: `cfg_ready` is high in every cycle out of reset, and each cycle with `cfg_valid` high is one accepted write.

Top module: `fault_inject_sched`

## Requirements
- R1: After reset, both interrupt outputs are 0, `done` and `inj_active` are 0, `inj_mask` is 0 and `cfg_ready` is 1.
- R2: Each `vp_pulse` opens a new block. The block index becomes 0 when `vp_first` is high with the pulse, and otherwise becomes the previous index plus 1. A `vp_first` pulse in the middle of a run restarts the numbering at 0.
- R3: Suppose an armed injection has target block B and offset K, and the rising edge that samples `vp_pulse` opens block B. Then `irq_core0` and `irq_core1` are both high for exactly one cycle: the cycle that follows the (K+1)-th rising edge after the sampling edge.
- R4: From the interrupt cycle onward, `inj_core` equals the configured core, `inj_reg` equals the configured register (0 to 15) and `inj_mask` equals 1 shifted left by the configured bit (0 to 31). `inj_active` is 1. All of these hold until `inj_ack` is sampled. After the acknowledge, `inj_active` is 0 and `inj_mask` is 0.
- R5: Injection is one-shot. When it fires, `done` becomes 1. No further interrupt occurs on later blocks until a new configuration write.
- R6: A configuration write with `cfg_arm` = 0 disables injection, also when it arrives during the wait or during the count. No interrupt follows.
- R7: A configuration write with `cfg_arm` = 1 while an injection is pending discards the old configuration. The sequence restarts: the block waits for the new target block and counts the new offset.
- R8: If a new block opens before the offset is reached, the pending count is dropped and the block waits again. No interrupt occurs unless the target block is opened again later.
- R9: Every configuration write clears `done` and `inj_active`.
- R10: A `vp_pulse` sampled in the same cycle as a configuration write still updates the block index, but it does not start the count for that write. Only later verification points are matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_ready | output | 1 | Always 1: writes are never stalled |
| cfg_arm | input | 1 | 1 arms an injection, 0 disables injection |
| cfg_block | input | 8 | Target code-block index |
| cfg_offset | input | 16 | Cycle offset within the target block |
| cfg_core | input | 1 | Core to corrupt (0 or 1) |
| cfg_reg | input | 4 | Register index to corrupt |
| cfg_bit | input | 5 | Bit index to flip |
| vp_pulse | input | 1 | One-cycle pulse on each verification-point entry |
| vp_first | input | 1 | Qualifies `vp_pulse` as the point that opens execution |
| inj_ack | input | 1 | Software acknowledge of a delivered injection |
| irq_core0 | output | 1 | Injection interrupt to core 0 |
| irq_core1 | output | 1 | Injection interrupt to core 1 |
| inj_active | output | 1 | Injection descriptor is valid and held |
| inj_core | output | 1 | Core whose register is flipped |
| inj_reg | output | 4 | Register index to flip |
| inj_mask | output | 32 | One-hot XOR mask |
| done | output | 1 | The armed injection has fired |

## Verification
Two kinds of internal fault show up at the ports. A wrong block index or cycle count moves the interrupt to the wrong cycle, and a dropped or spurious state transition adds or removes an interrupt. A cycle-stamped scoreboard catches either on the exact cycle where the interrupt appears or should have appeared. Descriptor faults, such as a wrong mask bit or a field that drifts before acknowledge, are visible in the same interrupt cycle and in the cycles up to `inj_ack`. Stale state after a reconfiguration or disarm appears as an unexpected interrupt some blocks later, and the scoreboard reports any interrupt it did not expect.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [1:0] {
    FIS_IDLE  = 2'd0,
    FIS_WAIT  = 2'd1,
    FIS_COUNT = 2'd2
  } fis_state_e;
endpackage

// File: rtl/fis_block_track.sv
module fis_block_track #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vp_pulse,
  input  logic             vp_first,
  output logic [BLK_W-1:0] enter_idx
);
  logic [BLK_W-1:0] blk_q;

  // index of the block opened by the current verification point (R2)
  assign enter_idx = vp_first ? '0 : blk_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)        blk_q <= '0;
    else if (vp_pulse) blk_q <= enter_idx;
  end
endmodule

// File: rtl/fis_cycle_timer.sv
module fis_cycle_timer #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [OFS_W-1:0] limit,
  output logic             hit
);
  logic [OFS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign hit = run && (cnt_q == limit);
endmodule

// File: rtl/fis_mask_gen.sv
module fis_mask_gen #(
  parameter int XLEN  = 32,
  parameter int BIT_W = 5
) (
  input  logic [BIT_W-1:0] bit_idx,
  output logic [XLEN-1:0]  mask
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign mask[i] = (bit_idx == BIT_W'(i));
  end
endmodule

// File: rtl/fault_inject_sched.sv
module fault_inject_sched
  import fis_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int OFS_W = 16,
  parameter int REG_N = 16,
  parameter int XLEN  = 32,
  localparam int REG_W = $clog2(REG_N),
  localparam int BIT_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_arm,
  input  logic [BLK_W-1:0] cfg_block,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic             cfg_core,
  input  logic [REG_W-1:0] cfg_reg,
  input  logic [BIT_W-1:0] cfg_bit,
  input  logic             vp_pulse,
  input  logic             vp_first,
  input  logic             inj_ack,
  output logic             irq_core0,
  output logic             irq_core1,
  output logic             inj_active,
  output logic             inj_core,
  output logic [REG_W-1:0] inj_reg,
  output logic [XLEN-1:0]  inj_mask,
  output logic             done
);
  fis_state_e       st_q;
  logic [BLK_W-1:0] tgt_blk_q;
  logic [OFS_W-1:0] tgt_ofs_q;
  logic             tgt_core_q;
  logic [REG_W-1:0] tgt_reg_q;
  logic [BIT_W-1:0] tgt_bit_q;
  logic [BLK_W-1:0] enter_idx;
  logic [XLEN-1:0]  mask_w;
  logic             hit, opens_target, timer_clear;
  logic             irq_q;

  assign cfg_ready = 1'b1;

  fis_block_track #(.BLK_W(BLK_W)) u_track (
    .clk(clk), .rst_n(rst_n), .vp_pulse(vp_pulse), .vp_first(vp_first),
    .enter_idx(enter_idx)
  );

  assign opens_target = vp_pulse && (enter_idx == tgt_blk_q)
                     && (st_q != FIS_IDLE);
  assign timer_clear  = cfg_valid || opens_target;

  fis_cycle_timer #(.OFS_W(OFS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear),
    .run(st_q == FIS_COUNT && !cfg_valid), .limit(tgt_ofs_q), .hit(hit)
  );

  fis_mask_gen #(.XLEN(XLEN), .BIT_W(BIT_W)) u_mask (
    .bit_idx(tgt_bit_q), .mask(mask_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= FIS_IDLE;
      tgt_blk_q  <= '0;
      tgt_ofs_q  <= '0;
      tgt_core_q <= 1'b0;
      tgt_reg_q  <= '0;
      tgt_bit_q  <= '0;
      irq_q      <= 1'b0;
      inj_active <= 1'b0;
      inj_core   <= 1'b0;
      inj_reg    <= '0;
      inj_mask   <= '0;
      done       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_valid) begin
        tgt_blk_q  <= cfg_block;
        tgt_ofs_q  <= cfg_offset;
        tgt_core_q <= cfg_core;
        tgt_reg_q  <= cfg_reg;
        tgt_bit_q  <= cfg_bit;
        st_q       <= cfg_arm ? FIS_WAIT : FIS_IDLE;
        done       <= 1'b0;
        inj_active <= 1'b0;
        inj_core   <= 1'b0;
        inj_reg    <= '0;
        inj_mask   <= '0;
      end else begin
        if (inj_ack) begin
          inj_active <= 1'b0;
          inj_core   <= 1'b0;
          inj_reg    <= '0;
          inj_mask   <= '0;
        end
        unique case (st_q)
          FIS_WAIT: begin
            if (opens_target) st_q <= FIS_COUNT;
          end
          FIS_COUNT: begin
            if (hit) begin
              st_q       <= FIS_IDLE;
              irq_q      <= 1'b1;
              done       <= 1'b1;
              inj_active <= 1'b1;
              inj_core   <= tgt_core_q;
              inj_reg    <= tgt_reg_q;
              inj_mask   <= mask_w;
            end else if (vp_pulse) begin
              st_q <= opens_target ? FIS_COUNT : FIS_WAIT;
            end
          end
          default: st_q <= FIS_IDLE;
        endcase
      end
    end
  end

  assign irq_core0 = irq_q;
  assign irq_core1 = irq_q;
endmodule

// File: rtl/fis_checker.sv
module fis_checker #(
  parameter int REG_W = 4,
  parameter int XLEN  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             inj_ack,
  input logic             irq_core0,
  input logic             irq_core1,
  input logic             inj_active,
  input logic             inj_core,
  input logic [REG_W-1:0] inj_reg,
  input logic [XLEN-1:0]  inj_mask,
  input logic             done
);
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_core0 |=> !irq_core0 && !irq_core1); // R3

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inj_mask) && (inj_active || inj_mask == '0)); // R4

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    inj_active && !inj_ack && !cfg_valid |=>
      inj_active && $stable(inj_core) && $stable(inj_reg) && $stable(inj_mask)); // R4

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ack && !cfg_valid |=> !inj_active && inj_mask == '0); // R4

  AST_FIRE_MARKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_core0 |-> done && inj_active); // R5

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cfg_valid |=> !irq_core0 && !irq_core1); // R5

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !done && !inj_active); // R9
endmodule

bind fault_inject_sched fis_checker #(.REG_W(REG_W), .XLEN(XLEN)) u_fis_checker (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .inj_ack(inj_ack),
  .irq_core0(irq_core0), .irq_core1(irq_core1), .inj_active(inj_active),
  .inj_core(inj_core), .inj_reg(inj_reg), .inj_mask(inj_mask), .done(done)
);

// File: tb/fault_inject_sched_bench.sv
`timescale 1ns/1ps
module fault_inject_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0, cfg_arm = 1'b0, cfg_core = 1'b0;
  logic [7:0]  cfg_block = '0;
  logic [15:0] cfg_offset = '0;
  logic [3:0]  cfg_reg = '0;
  logic [4:0]  cfg_bit = '0;
  logic        vp_pulse = 1'b0, vp_first = 1'b0, inj_ack = 1'b0;
  logic        cfg_ready, irq_core0, irq_core1, inj_active, inj_core, done;
  logic [3:0]  inj_reg;
  logic [31:0] inj_mask;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int          at;
    logic        core;
    logic [3:0]  rg;
    logic [31:0] mask;
  } exp_t;
  exp_t sb_q[$];

  // current configuration as seen by the driver
  logic        cur_core;
  logic [3:0]  cur_reg;
  logic [4:0]  cur_bit;
  logic [15:0] cur_ofs;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fault_inject_sched u_fault_inject_sched (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_arm(cfg_arm), .cfg_block(cfg_block), .cfg_offset(cfg_offset),
    .cfg_core(cfg_core), .cfg_reg(cfg_reg), .cfg_bit(cfg_bit),
    .vp_pulse(vp_pulse), .vp_first(vp_first), .inj_ack(inj_ack),
    .irq_core0(irq_core0), .irq_core1(irq_core1), .inj_active(inj_active),
    .inj_core(inj_core), .inj_reg(inj_reg), .inj_mask(inj_mask), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every interrupt
  always @(negedge clk) begin
    if (rst_n && (irq_core0 || irq_core1)) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R5/R6/R8 unexpected interrupt", cyc, -1);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(cyc == e.at, "R3 interrupt cycle", cyc, e.at);
        chk(irq_core0 && irq_core1, "R3 both cores", {irq_core0, irq_core1}, 2'b11);
        chk(inj_core == e.core, "R4 core", inj_core, e.core);
        chk(inj_reg == e.rg, "R4 register", inj_reg, e.rg);
        chk(inj_mask == e.mask, "R4 mask", inj_mask, e.mask);
      end
    end
  end

  task automatic cfg_write(input logic arm, input logic [7:0] blk, input logic [15:0] ofs,
                           input logic core, input logic [3:0] rg, input logic [4:0] bt,
                           input bit with_vp, input bit first);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_arm = arm; cfg_block = blk; cfg_offset = ofs;
    cfg_core = core; cfg_reg = rg; cfg_bit = bt;
    vp_pulse = with_vp; vp_first = first;
    cur_core = core; cur_reg = rg; cur_bit = bt; cur_ofs = ofs;
    @(negedge clk);
    cfg_valid = 1'b0; vp_pulse = 1'b0; vp_first = 1'b0;
  endtask

  // driver: a verification point, optionally predicting the injection
  task automatic vp(input bit first, input bit expect_fire);
    @(negedge clk);
    vp_pulse = 1'b1; vp_first = first;
    if (expect_fire) begin
      exp_t e;
      e.at = cyc + 1 + int'(cur_ofs) + 1;
      e.core = cur_core; e.rg = cur_reg; e.mask = 32'd1 << cur_bit;
      sb_q.push_back(e);
    end
    @(negedge clk);
    vp_pulse = 1'b0; vp_first = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); inj_ack = 1'b1;
    @(negedge clk); inj_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!irq_core0 && !irq_core1, "R1 irq idle", {irq_core0, irq_core1}, 0);
    chk(!done && !inj_active, "R1 flags clear", {done, inj_active}, 0);
    chk(inj_mask == 0, "R1 mask clear", inj_mask, 0);
    chk(cfg_ready, "R1 ready high", cfg_ready, 1);

    // R2 R3 R4: block 2, offset 5
    cfg_write(1'b1, 8'd2, 16'd5, 1'b1, 4'd7, 5'd13, 0, 0);
    vp(1, 0); idle(3); vp(0, 0); idle(3); vp(0, 1);
    idle(12);
    chk(done, "R5 done after fire", done, 1);
    chk(inj_active && inj_reg == 4'd7 && inj_core, "R4 held until ack", inj_reg, 7);
    chk(inj_mask == 32'h0000_2000, "R4 mask held", inj_mask, 32'h2000);
    ack(); @(negedge clk);
    chk(!inj_active && inj_mask == 0, "R4 ack releases", inj_mask, 0);

    // R5 one-shot: later blocks produce nothing
    vp(1, 0); idle(2); vp(0, 0); idle(2); vp(0, 0); idle(20);
    chk(done, "R5 done persists", done, 1);

    // R2 mid-run restart of numbering, target block 3 offset 0
    cfg_write(1'b1, 8'd3, 16'd0, 1'b0, 4'd2, 5'd0, 0, 0);
    chk(!done, "R9 write clears done", done, 0);
    vp(1, 0); vp(0, 0); vp(0, 0); vp(1, 0); vp(0, 0); vp(0, 0); vp(0, 1);
    idle(5); ack();

    // R8 window missed, then block reopened
    cfg_write(1'b1, 8'd1, 16'd20, 1'b0, 4'd4, 5'd7, 0, 0);
    vp(1, 0); idle(2); vp(0, 0); idle(5); vp(0, 0); idle(30);
    chk(!done, "R8 missed window no fire", done, 0);
    vp(1, 0); idle(2); vp(0, 1); idle(25);
    chk(done && inj_mask == 32'h80, "R8 fires on reopen", inj_mask, 32'h80);
    ack();

    // R6 disarm before and during count
    cfg_write(1'b1, 8'd0, 16'd3, 1'b1, 4'd1, 5'd1, 0, 0);
    cfg_write(1'b0, 8'd0, 16'd3, 1'b1, 4'd1, 5'd1, 0, 0);
    vp(1, 0); idle(20);
    chk(!done, "R6 disarmed before block", done, 0);
    cfg_write(1'b1, 8'd0, 16'd10, 1'b1, 4'd1, 5'd1, 0, 0);
    vp(1, 0); idle(3);
    cfg_write(1'b0, 8'd0, 16'd10, 1'b1, 4'd1, 5'd1, 0, 0);
    idle(20);
    chk(!done && !inj_active, "R6 disarmed during count", done, 0);

    // R7 rearm while counting restarts with new config
    cfg_write(1'b1, 8'd0, 16'd10, 1'b0, 4'd3, 5'd0, 0, 0);
    vp(1, 0); idle(3);
    cfg_write(1'b1, 8'd0, 16'd0, 1'b0, 4'd15, 5'd31, 0, 0);
    idle(15);
    chk(!done, "R7 old config discarded", done, 0);
    vp(1, 1); idle(5);
    chk(inj_reg == 4'd15 && inj_mask == 32'h8000_0000, "R7 new config", inj_mask, 32'h8000_0000);
    ack();

    // R10 verification point in the write cycle is not matched
    cfg_write(1'b1, 8'd0, 16'd2, 1'b1, 4'd9, 5'd4, 1, 1);
    idle(10);
    chk(!done, "R10 same-cycle point ignored", done, 0);
    vp(1, 1); idle(6);
    chk(done && inj_core, "R10 later point matched", done, 1);
    ack(); idle(4);

    chk(sb_q.size() == 0, "R3 all predicted interrupts seen", sb_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule